// File: doc/BRIEF.md
# Serial Clock-Calendar with Battery RAM

This block is the device end of a three-wire serial link to a clock-calendar. A host drives a chip-enable line, a serial clock and a data bit. The block answers on a separate data-out pin with an output enable, so a bridge can merge the two onto one shared wire. Each exchange is sixteen serial clock bits. The first eight bits are a command byte. The second eight bits are a value byte. For read commands, the block returns a byte in the second half of the exchange.

The block holds thirty-two bytes of non-volatile RAM, a status byte, a control byte and a set of time registers in BCD. A one-cycle tick input advances seconds, minutes and hours. Day, month and year are fixed BCD values set by parameters.

RAM writes and the status-clear command take effect only when the sixteenth bit completes. Dropping chip enable earlier abandons the exchange with no effect. The interrupt request output is high while either of the two status event bits (bit 3, bit 4) is set.

Top module: `rtc_serial_slave`

## Requirements
- R1: A bit is taken from `sdi` only on a falling edge of `sclk` while `ce` is high. Falling edges seen while `ce` is low shift nothing.
- R2: The first eight bits form the command and the next eight form the value, both most significant bit first.
- R3: For a command in 0x00..0x1F, `sdo_oe` is high during bits 8 to 15 and `sdo` presents RAM byte [command], bit 7 first. `sdo_oe` is low in the command phase.
- R4: Command 0x30 returns the status byte and command 0x31 returns the control byte (0x00), in the same data-phase format as R3.
- R5: Commands 0x20, 0x21, 0x22, 0x24, 0x25 and 0x26 return seconds, minutes, hours, day, month and year in BCD. The other codes 0x23 and 0x27..0x2F return 0x00.
- R6: A command in 0x80..0x9F writes the value to RAM address (command - 0x80) when the sixteenth bit completes. Write commands never assert `sdo_oe`.
- R7: Command 0xB1 with value bit 2 set clears status bits 4 and 3 (mask 0x18). With bit 2 clear, the status is unchanged. `irq` is high exactly when status bit 4 or bit 3 is set.
- R8: Lowering `ce` before the sixteenth bit discards the exchange: no RAM or status change, and the bit count, command and value return to zero.
- R9: Bits clocked after the sixteenth are ignored until `ce` drops. They cause no write and no output enable.
- R10: After reset the status is 0x90, every RAM byte is 0x00, the time reads 00:00:00, `irq` is high and `sdo_oe` is low.
- R11: Each `tick` cycle advances the BCD seconds. Seconds roll from 59 to 00 and carry into minutes. Minutes roll from 59 to 00 and carry into hours. Hours roll from 23 to 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all serial lines are sampled with it |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce | input | 1 | Serial chip enable, high for the whole exchange |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| tick | input | 1 | One-cycle pulse advancing the seconds count |
| sdo | output | 1 | Serial read data during the data phase |
| sdo_oe | output | 1 | High while `sdo` should drive the shared wire |
| irq | output | 1 | Interrupt request, high while a status event bit is set |

## Verification
On every cycle, the assertions check the following. The output enable is confined to an enabled data phase. The bit count never passes sixteen and clears after chip enable drops. RAM changes only at a completed sixteenth bit. The interrupt falls only on a completed status-clear command. The time registers hold legal BCD digits.

Only the bench scenarios can show that the right byte comes out in the right bit order. The same goes for aborted and over-long exchanges leaving storage untouched, undefined time codes reading zero, and the full-day roll-over of the clock.

// File: rtl/rtc_serial_slave.sv
module rtc_serial_slave #(
  parameter int          RAM_DEPTH  = 32,
  parameter logic [7:0]  STATUS_RST = 8'h90,
  parameter logic [7:0]  CTRL_VAL   = 8'h00,
  parameter logic [7:0]  DAY_BCD    = 8'h15,
  parameter logic [7:0]  MONTH_BCD  = 8'h07,
  parameter logic [7:0]  YEAR_BCD   = 8'h24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce,
  input  logic sclk,
  input  logic sdi,
  input  logic tick,
  output logic sdo,
  output logic sdo_oe,
  output logic irq
);
  localparam int         AW        = $clog2(RAM_DEPTH);
  localparam logic [4:0] LAST_BIT  = 5'd15;
  localparam logic [4:0] FULL      = 5'd16;
  localparam logic [7:0] WR_BASE   = 8'h80;
  localparam logic [7:0] EVT_MASK  = 8'h18;

  logic                          sclk_q;
  logic [4:0]                    cnt_q;
  logic [7:0]                    cmd_q, val_q;
  logic [RAM_DEPTH-1:0][7:0]     ram_q;
  logic [7:0]                    status_q;
  logic [7:0]                    sec_q, min_q, hour_q;

  wire       fall    = ce & sclk_q & ~sclk;
  wire       commit  = fall && (cnt_q == LAST_BIT);
  wire [7:0] val_nxt = {val_q[6:0], sdi};
  wire       is_wr   = (cmd_q >= WR_BASE) && (cmd_q < WR_BASE + 8'(RAM_DEPTH));
  wire       is_clr  = (cmd_q == 8'hB1);
  wire [7:0] wr_off  = cmd_q - WR_BASE;
  wire [AW-1:0] wr_addr = wr_off[AW-1:0];
  wire [AW-1:0] rd_addr = cmd_q[AW-1:0];
  wire       data_ph = (cnt_q >= 5'd8) && (cnt_q < FULL);

  logic       rd_ok;
  logic [7:0] rd_byte;

  always_comb begin
    rd_ok   = 1'b1;
    rd_byte = 8'h00;
    if (cmd_q < 8'(RAM_DEPTH)) rd_byte = ram_q[rd_addr];
    else begin
      case (cmd_q)
        8'h20:   rd_byte = sec_q;
        8'h21:   rd_byte = min_q;
        8'h22:   rd_byte = hour_q;
        8'h24:   rd_byte = DAY_BCD;
        8'h25:   rd_byte = MONTH_BCD;
        8'h26:   rd_byte = YEAR_BCD;
        8'h30:   rd_byte = status_q;
        8'h31:   rd_byte = CTRL_VAL;
        default: begin
          rd_byte = 8'h00;
          rd_ok   = (cmd_q[7:4] == 4'h2);
        end
      endcase
    end
  end

  assign sdo_oe = ce & data_ph & rd_ok;
  assign sdo    = sdo_oe & rd_byte[~cnt_q[2:0]];
  assign irq    = |(status_q & EVT_MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cmd_q <= '0;
      val_q <= '0;
    end else if (!ce) begin
      cnt_q <= '0;
      cmd_q <= '0;
      val_q <= '0;
    end else if (fall && cnt_q < FULL) begin
      cnt_q <= cnt_q + 5'd1;
      if (cnt_q < 5'd8) cmd_q <= {cmd_q[6:0], sdi};
      else              val_q <= val_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ram_q <= '0;
    else if (commit && is_wr) ram_q[wr_addr] <= val_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= STATUS_RST;
    else if (commit && is_clr && val_nxt[2]) status_q <= status_q & ~EVT_MASK;
  end

  function automatic logic [7:0] bcd_step(input logic [7:0] v, input logic [7:0] top);
    if (v == top)          return 8'h00;
    else if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                   return {v[7:4], v[3:0] + 4'd1};
  endfunction

  wire sec_wrap = tick && (sec_q == 8'h59);
  wire min_wrap = sec_wrap && (min_q == 8'h59);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q  <= 8'h00;
      min_q  <= 8'h00;
      hour_q <= 8'h00;
    end else begin
      if (tick)     sec_q  <= bcd_step(sec_q, 8'h59);
      if (sec_wrap) min_q  <= bcd_step(min_q, 8'h59);
      if (min_wrap) hour_q <= bcd_step(hour_q, 8'h23);
    end
  end
endmodule

module rtc_serial_slave_chk #(
  parameter int RAM_DEPTH = 32
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      ce,
  input logic                      sdo_oe,
  input logic                      irq,
  input logic                      fall,
  input logic [4:0]                cnt_q,
  input logic [7:0]                cmd_q,
  input logic [RAM_DEPTH-1:0][7:0] ram_q,
  input logic [7:0]                sec_q,
  input logic [7:0]                min_q,
  input logic [7:0]                hour_q
);
  p_oe_in_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |-> (ce && cnt_q >= 5'd8 && cnt_q <= 5'd15));

  p_abort_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> (cnt_q == 5'd0 && cmd_q == 8'h00));

  p_no_overrun_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= 5'd16);

  p_ram_commit_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(fall && cnt_q == 5'd15) |=> $stable(ram_q));

  p_irq_clear_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> (cmd_q == 8'hB1 && cnt_q == 5'd16));

  p_bcd_legal_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_q[3:0] <= 4'd9 && sec_q[7:4] <= 4'd5 &&
     min_q[3:0] <= 4'd9 && min_q[7:4] <= 4'd5 &&
     hour_q[3:0] <= 4'd9 && hour_q <= 8'h23));
endmodule

bind rtc_serial_slave rtc_serial_slave_chk #(.RAM_DEPTH(RAM_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce(ce), .sdo_oe(sdo_oe), .irq(irq),
  .fall(fall), .cnt_q(cnt_q), .cmd_q(cmd_q), .ram_q(ram_q),
  .sec_q(sec_q), .min_q(min_q), .hour_q(hour_q)
);

// File: tb/tb_rtc_serial_slave.sv
module tb_rtc_serial_slave;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ce = 1'b0, sclk = 1'b0, sdi = 1'b0, tick = 1'b0;
  logic sdo, sdo_oe, irq;
  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  rtc_serial_slave dut (
    .clk(clk), .rst_n(rst_n), .ce(ce), .sclk(sclk), .sdi(sdi), .tick(tick),
    .sdo(sdo), .sdo_oe(sdo_oe), .irq(irq)
  );

  // {is_read, cmd, value, expected}
  localparam int NV = 17;
  localparam logic [24:0] VEC [NV] = '{
    {1'b0, 8'h85, 8'h3C, 8'h00},
    {1'b1, 8'h05, 8'h00, 8'h3C},
    {1'b0, 8'h9F, 8'hA5, 8'h00},
    {1'b1, 8'h1F, 8'h00, 8'hA5},
    {1'b0, 8'h80, 8'h01, 8'h00},
    {1'b1, 8'h00, 8'h00, 8'h01},
    {1'b1, 8'h07, 8'h00, 8'h00},
    {1'b1, 8'h30, 8'h00, 8'h90},
    {1'b0, 8'hB1, 8'hFB, 8'h00},
    {1'b1, 8'h30, 8'h00, 8'h90},
    {1'b1, 8'h31, 8'h00, 8'h00},
    {1'b1, 8'h24, 8'h00, 8'h15},
    {1'b1, 8'h25, 8'h00, 8'h07},
    {1'b1, 8'h26, 8'h00, 8'h24},
    {1'b1, 8'h23, 8'h00, 8'h00},
    {1'b1, 8'h2F, 8'h00, 8'h00},
    {1'b1, 8'h20, 8'h00, 8'h00}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic string req_of(input logic [7:0] c);
    if (c < 8'h20)              return "R3";
    if (c == 8'h30 || c == 8'h31) return "R4";
    if (c[7:4] == 4'h2)          return "R5";
    if (c == 8'hB1)              return "R7";
    return "R6";
  endfunction

  // nbits: serial bits sent before ce drops; rd/oe gather data-phase samples
  task automatic xfer(input logic [7:0] c, input logic [7:0] w, input int nbits,
                      output logic [7:0] rd, output logic [7:0] oe, output logic stray);
    rd = '0; oe = '0; stray = 1'b0;
    ce = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdi  = (i < 8) ? c[7-i] : (i < 16) ? w[15-i] : 1'b1;
      sclk = 1'b1;
      repeat (3) @(negedge clk);
      if (i >= 8 && i < 16) begin
        rd[15-i] = sdo;
        oe[15-i] = sdo_oe;
      end else if (sdo_oe) stray = 1'b1;
      sclk = 1'b0;
      repeat (3) @(negedge clk);
    end
    ce = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd_chk(input string req, input logic [7:0] c, input logic [7:0] exp);
    logic [7:0] rd, oe;
    logic st;
    xfer(c, 8'h00, 16, rd, oe, st);
    check(req, {24'h0, rd}, {24'h0, exp});
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    logic [7:0] rd, oe;
    logic st;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: reset state
    check("R10 irq", {31'h0, irq}, 32'h1);
    check("R10 sdo_oe", {31'h0, sdo_oe}, 32'h0);

    // R1: falling edges with ce low must not disturb the next exchange
    for (int k = 0; k < 9; k++) begin
      sdi = 1'b1; sclk = 1'b1; repeat (2) @(negedge clk);
      sclk = 1'b0; repeat (2) @(negedge clk);
    end
    check("R1 no oe with ce low", {31'h0, sdo_oe}, 32'h0);
    rd_chk("R1 status after idle clocks", 8'h30, 8'h90);

    // R2/R3/R4/R5/R6/R7: vector table
    for (int v = 0; v < NV; v++) begin
      xfer(VEC[v][23:16], VEC[v][15:8], 16, rd, oe, st);
      check({req_of(VEC[v][23:16]), " cmd-phase oe"}, {31'h0, st}, 32'h0);
      if (VEC[v][24]) begin
        check({req_of(VEC[v][23:16]), " R2 data"}, {24'h0, rd}, {24'h0, VEC[v][7:0]});
        check({req_of(VEC[v][23:16]), " oe window"}, {24'h0, oe}, 32'hFF);
      end else begin
        check("R6 write oe", {24'h0, oe}, 32'h0);
      end
    end
    check("R7 irq kept", {31'h0, irq}, 32'h1);

    // R10: untouched RAM reads zero
    rd_chk("R10 ram zero", 8'h11, 8'h00);

    // R8: aborted write after 12 bits
    xfer(8'h82, 8'h77, 12, rd, oe, st);
    rd_chk("R8 abort no write", 8'h02, 8'h00);
    // R8: aborted clear leaves status
    xfer(8'hB1, 8'h04, 15, rd, oe, st);
    check("R8 irq after abort", {31'h0, irq}, 32'h1);

    // R9: four extra bits after a complete write
    xfer(8'h83, 8'h55, 20, rd, oe, st);
    check("R9 no oe on extra bits", {31'h0, st}, 32'h0);
    rd_chk("R9 write kept", 8'h03, 8'h55);
    // R9: extra bits after a read don't re-enable output
    xfer(8'h03, 8'h00, 20, rd, oe, st);
    check("R9 read extra oe", {31'h0, st}, 32'h0);
    check("R9 read data", {24'h0, rd}, 32'h55);

    // R7: clear events
    xfer(8'hB1, 8'h04, 16, rd, oe, st);
    check("R7 irq cleared", {31'h0, irq}, 32'h0);
    rd_chk("R7 status cleared", 8'h30, 8'h80);

    // R11: time counting
    ticks(61);
    rd_chk("R11 sec", 8'h20, 8'h01);
    rd_chk("R11 min", 8'h21, 8'h01);
    ticks(86399 - 61);
    rd_chk("R11 sec 59", 8'h20, 8'h59);
    rd_chk("R11 min 59", 8'h21, 8'h59);
    rd_chk("R11 hour 23", 8'h22, 8'h23);
    ticks(1);
    rd_chk("R11 sec wrap", 8'h20, 8'h00);
    rd_chk("R11 min wrap", 8'h21, 8'h00);
    rd_chk("R11 hour wrap", 8'h22, 8'h00);

    finish_up();
  end
endmodule